// File: doc/BRIEF.md
# DRAM Idle Low-Power State Sequencer

This block watches a single bus-activity flag from a memory controller and counts how many DFI clock cycles in a row the bus has stayed quiet. The DFI clock runs at half the DRAM clock rate, so every count and threshold here is in half-rate cycles. As the quiet time grows past a set of programmable limits, the block steps the memory down through deeper low-power states. The states, from shallowest to deepest, are power-down, self-refresh, self-refresh with the controller clock gated, self-refresh power-down (LPDDR4 only), and standby. In standby the controller, PHY-interface, PHY and DRAM clocks are all gated.

The power-down and standby limits are plain cycle counts. The three self-refresh limits are in units of 1024 cycles. A limit of zero turns its stage off, and the walk then passes over that stage. When the bus wakes up, the block first turns every gated clock back on. It then drops its self-refresh and power-down requests and waits for an exit acknowledge before it calls the memory active again. The block outputs an encoded state and a one-cycle change pulse for a performance monitor.

Top module: `lp_idle_seq`

## Requirements
- R1: While reset is held, and after it is released with the bus busy, the outputs are as follows. `lp_state` is 0 (active). `pd_req` and `sr_req` are low. All four clock enables are high. `state_chg` is low.
- R2: The idle count goes up by one on each clock edge at which `bus_busy` is low. From active, the block enters power-down (`lp_state` 1, `pd_req` high) on the edge that follows the edge at which the count reaches `pd_thr`, counted in raw cycles.
- R3: From power-down, the block enters self-refresh (`lp_state` 2, `sr_req` high, `pd_req` low). This happens on the edge after the idle count reaches `sr_thr`×1024.
- R4: Each stage is entered only from the nearest shallower stage that is enabled. A stage whose limit is zero is passed over. A state with no enabled deeper stage is held for as long as the bus stays idle.
- R5: Self-refresh with clock gating (`lp_state` 3) is entered on the edge after the count reaches `srcg_thr`×1024. In this state `sr_req` stays high and only `ctl_clk_en` is low.
- R6: Self-refresh power-down (`lp_state` 4, `sr_req` and `pd_req` both high, `ctl_clk_en` low) uses `srpd_thr`×1024. It is entered only when `dram_type` equals 2 (LPDDR4). For any other type the stage is passed over.
- R7: Standby (`lp_state` 5) is entered on the edge after the count reaches `sb_thr`, counted in raw cycles. In standby `sr_req` is high, `pd_req` is low, and all four clock enables are low.
- R8: Exit from a low-power state happens in this order:
  - On the first edge at which `bus_busy` is high, the block goes to `lp_state` 6. All four clocks are enabled, and `pd_req`/`sr_req` keep their values.
  - On the next edge it goes to `lp_state` 7, with both requests low.
  - It returns to `lp_state` 0 only on the edge at which `exit_ack` is high.
- R9: The idle count is cleared on any edge at which `bus_busy` is high, and it does not wrap. `bus_busy` in the active state keeps the block active. `bus_busy` in state 7 has no effect.
- R10: `state_chg` is high for exactly the cycle that follows each edge at which `lp_state` changes, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DFI clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_busy | input | 1 | Memory bus activity flag, high when a transfer is pending |
| exit_ack | input | 1 | Low-power exit completed by the command logic |
| dram_type | input | 2 | Memory type: 0 DDR3, 1 LPDDR3, 2 LPDDR4 |
| pd_thr | input | 12 | Power-down idle limit in cycles, 0 disables |
| sr_thr | input | 12 | Self-refresh idle limit in 1024-cycle units, 0 disables |
| srcg_thr | input | 12 | Self-refresh with controller clock gating limit in 1024-cycle units, 0 disables |
| srpd_thr | input | 12 | Self-refresh power-down limit in 1024-cycle units, 0 disables |
| sb_thr | input | 12 | Standby idle limit in cycles, 0 disables |
| pd_req | output | 1 | Power-down request |
| sr_req | output | 1 | Self-refresh request |
| ctl_clk_en | output | 1 | Controller clock enable |
| pi_clk_en | output | 1 | PHY-interface clock enable |
| phy_clk_en | output | 1 | PHY clock enable |
| dram_clk_en | output | 1 | DRAM clock enable |
| lp_state | output | 3 | Encoded current state, 0 to 7 as listed in the requirements |
| state_chg | output | 1 | One-cycle pulse after each state change |

## Verification
A stage entry lands on the edge after the edge at which the idle count equals its limit. The count equals k after the k-th edge that follows the last busy edge, so the bench checks each entry at count limit and again at limit plus one. Exit steps each take one edge from the stimulus: busy sampled, then one more edge, then the acknowledge edge. The bench drives inputs on falling edges and checks after exactly one rising edge. The change pulse is checked in the cycle of each change and in the cycle after it.

// File: rtl/lp_idle_pkg.sv
package lp_idle_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_PD     = 3'd1,
    ST_SR     = 3'd2,
    ST_SRCG   = 3'd3,
    ST_SRPD   = 3'd4,
    ST_STBY   = 3'd5,
    ST_EXCLK  = 3'd6,
    ST_EXWAIT = 3'd7
  } lp_state_e;

  localparam int          NUM_STAGE = 5;
  localparam logic [1:0]  MEM_LP4   = 2'd2;

  typedef struct packed {
    logic pd;
    logic sr;
    logic ctl;
    logic pi;
    logic phy;
    logic dram;
  } lp_out_s;

  function automatic lp_out_s stage_out(lp_state_e s);
    lp_out_s o;
    o = '{pd: 1'b0, sr: 1'b0, ctl: 1'b1, pi: 1'b1, phy: 1'b1, dram: 1'b1};
    case (s)
      ST_PD:   o.pd = 1'b1;
      ST_SR:   o.sr = 1'b1;
      ST_SRCG: begin o.sr = 1'b1; o.ctl = 1'b0; end
      ST_SRPD: begin o.sr = 1'b1; o.pd = 1'b1; o.ctl = 1'b0; end
      ST_STBY: begin
        o.sr = 1'b1; o.ctl = 1'b0; o.pi = 1'b0; o.phy = 1'b0; o.dram = 1'b0;
      end
      default: ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/lp_idle_counter.sv
module lp_idle_counter #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_en  = clr || (cnt != CNT_MAX);
    cnt_nxt = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R9
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX)); // R9

endmodule

// File: rtl/lp_stage_pick.sv
module lp_stage_pick
  import lp_idle_pkg::*;
#(
  parameter int THR_W  = 12,
  parameter int KSHIFT = 10,
  localparam int CNT_W = THR_W + KSHIFT
) (
  input  lp_state_e                           cur,
  input  logic [CNT_W-1:0]                    idle_cnt,
  input  logic [NUM_STAGE:1][THR_W-1:0]       thr_v,
  input  logic                                is_lp4,
  output logic                                step,
  output lp_state_e                           tgt
);
  localparam logic [NUM_STAGE:1] SCALED = 5'b01110;

  logic [NUM_STAGE:1][CNT_W-1:0] lim;
  logic [NUM_STAGE:1]            en_v;

  for (genvar g = 1; g <= NUM_STAGE; g++) begin : g_lim
    if (SCALED[g]) begin : g_scaled
      assign lim[g] = {thr_v[g], {KSHIFT{1'b0}}};
    end else begin : g_raw
      assign lim[g] = {{KSHIFT{1'b0}}, thr_v[g]};
    end
    if (g == int'(ST_SRPD)) begin : g_lp4
      assign en_v[g] = (|thr_v[g]) && is_lp4;
    end else begin : g_any
      assign en_v[g] = |thr_v[g];
    end
  end

  always_comb begin
    logic found;
    int   cur_idx;
    found   = 1'b0;
    step    = 1'b0;
    tgt     = cur;
    cur_idx = int'(cur);
    if (cur_idx < NUM_STAGE) begin
      for (int i = 1; i <= NUM_STAGE; i++) begin
        if (!found && i > cur_idx && en_v[i]) begin
          found = 1'b1;
          if (idle_cnt >= lim[i]) begin
            step = 1'b1;
            tgt  = lp_state_e'(3'(i));
          end
        end
      end
    end
  end

endmodule

// File: rtl/lp_state_fsm.sv
module lp_state_fsm
  import lp_idle_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      busy,
  input  logic      exit_ack,
  input  logic      step,
  input  lp_state_e tgt,
  output lp_state_e st_q,
  output lp_out_s   o_q,
  output logic      chg_q
);
  lp_state_e st_nxt;
  lp_out_s   o_nxt;
  logic      st_en;

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_ACTIVE: if (!busy && step) st_nxt = tgt;
      ST_PD, ST_SR, ST_SRCG, ST_SRPD, ST_STBY: begin
        if (busy)      st_nxt = ST_EXCLK;
        else if (step) st_nxt = tgt;
      end
      ST_EXCLK:  st_nxt = ST_EXWAIT;
      ST_EXWAIT: if (exit_ack) st_nxt = ST_ACTIVE;
      default:   st_nxt = ST_ACTIVE;
    endcase
  end

  always_comb begin
    o_nxt = stage_out(st_nxt);
    if (st_nxt == ST_EXCLK) begin
      o_nxt.pd = o_q.pd;
      o_nxt.sr = o_q.sr;
    end
    st_en = (st_nxt != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ACTIVE;
      o_q   <= '{pd: 1'b0, sr: 1'b0, ctl: 1'b1, pi: 1'b1, phy: 1'b1, dram: 1'b1};
      chg_q <= 1'b0;
    end else begin
      chg_q <= st_en;
      if (st_en) begin
        st_q <= st_nxt;
        o_q  <= o_nxt;
      end
    end
  end

  AST_EXIT_CLOCKS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st_q inside {ST_PD, ST_SR, ST_SRCG, ST_SRPD, ST_STBY})
    |=> (st_q == ST_EXCLK && o_q.ctl && o_q.pi && o_q.phy && o_q.dram)); // R8
  AST_EXIT_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXCLK) |-> (o_q.pd == $past(o_q.pd) && o_q.sr == $past(o_q.sr))); // R8
  AST_EXIT_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXWAIT && !exit_ack) |=> (st_q == ST_EXWAIT)); // R8
  AST_GATE_NEEDS_SR: assert property (@(posedge clk) disable iff (!rst_n)
    !o_q.ctl |-> o_q.sr); // R5
  AST_CHG_MARKS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (st_q != $past(st_q))); // R10
  AST_NO_CHG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_q |-> $stable(st_q)); // R10

endmodule

// File: rtl/lp_idle_seq.sv
module lp_idle_seq
  import lp_idle_pkg::*;
#(
  parameter int THR_W  = 12,
  parameter int KSHIFT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_busy,
  input  logic             exit_ack,
  input  logic [1:0]       dram_type,
  input  logic [THR_W-1:0] pd_thr,
  input  logic [THR_W-1:0] sr_thr,
  input  logic [THR_W-1:0] srcg_thr,
  input  logic [THR_W-1:0] srpd_thr,
  input  logic [THR_W-1:0] sb_thr,
  output logic             pd_req,
  output logic             sr_req,
  output logic             ctl_clk_en,
  output logic             pi_clk_en,
  output logic             phy_clk_en,
  output logic             dram_clk_en,
  output logic [2:0]       lp_state,
  output logic             state_chg
);
  localparam int CNT_W = THR_W + KSHIFT;

  logic [1:0]                    rs_q;
  logic                          rst_s_n;
  logic [CNT_W-1:0]              idle_cnt;
  logic                          cnt_clr;
  logic [NUM_STAGE:1][THR_W-1:0] thr_v;
  logic                          is_lp4;
  logic                          step;
  lp_state_e                     tgt;
  lp_state_e                     st_q;
  lp_out_s                       o_q;
  logic                          chg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  assign thr_v   = {sb_thr, srpd_thr, srcg_thr, sr_thr, pd_thr};
  assign is_lp4  = (dram_type == MEM_LP4);
  assign cnt_clr = bus_busy || (st_q == ST_EXCLK) || (st_q == ST_EXWAIT);

  lp_idle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr   (cnt_clr),
    .cnt   (idle_cnt)
  );

  lp_stage_pick #(.THR_W(THR_W), .KSHIFT(KSHIFT)) u_pick (
    .cur      (st_q),
    .idle_cnt (idle_cnt),
    .thr_v    (thr_v),
    .is_lp4   (is_lp4),
    .step     (step),
    .tgt      (tgt)
  );

  lp_state_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .busy     (bus_busy),
    .exit_ack (exit_ack),
    .step     (step),
    .tgt      (tgt),
    .st_q     (st_q),
    .o_q      (o_q),
    .chg_q    (chg_q)
  );

  assign pd_req      = o_q.pd;
  assign sr_req      = o_q.sr;
  assign ctl_clk_en  = o_q.ctl;
  assign pi_clk_en   = o_q.pi;
  assign phy_clk_en  = o_q.phy;
  assign dram_clk_en = o_q.dram;
  assign lp_state    = st_q;
  assign state_chg   = chg_q;

  AST_SRPD_ONLY_LP4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q != ST_SRPD && dram_type != MEM_LP4) |=> (st_q != ST_SRPD)); // R6
  AST_BUSY_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_ACTIVE && bus_busy) |=> (st_q == ST_ACTIVE)); // R9

endmodule

// File: tb/lp_idle_seq_test.sv
module lp_idle_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int THR_W      = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bus_busy;
  logic             exit_ack;
  logic [1:0]       dram_type;
  logic [THR_W-1:0] pd_thr, sr_thr, srcg_thr, srpd_thr, sb_thr;
  logic             pd_req, sr_req, ctl_clk_en, pi_clk_en, phy_clk_en, dram_clk_en;
  logic [2:0]       lp_state;
  logic             state_chg;

  int n_chk = 0;
  int n_bad = 0;
  int idle_k = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_idle_seq uut (
    .clk (clk), .rst_n (rst_n), .bus_busy (bus_busy), .exit_ack (exit_ack),
    .dram_type (dram_type), .pd_thr (pd_thr), .sr_thr (sr_thr),
    .srcg_thr (srcg_thr), .srpd_thr (srpd_thr), .sb_thr (sb_thr),
    .pd_req (pd_req), .sr_req (sr_req), .ctl_clk_en (ctl_clk_en),
    .pi_clk_en (pi_clk_en), .phy_clk_en (phy_clk_en), .dram_clk_en (dram_clk_en),
    .lp_state (lp_state), .state_chg (state_chg)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clkv();
    return {ctl_clk_en, pi_clk_en, phy_clk_en, dram_clk_en};
  endfunction

  task automatic pulse_busy();
    bus_busy = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_busy = 1'b0;
    idle_k = 0;
  endtask

  task automatic adv_to(int k);
    repeat (k - idle_k) @(posedge clk);
    @(negedge clk);
    idle_k = k;
  endtask

  task automatic setup(int ty, int p, int s, int g, int d, int b);
    bus_busy = 1'b1;
    dram_type = 2'(ty);
    pd_thr = THR_W'(p); sr_thr = THR_W'(s); srcg_thr = THR_W'(g);
    srpd_thr = THR_W'(d); sb_thr = THR_W'(b);
    pulse_busy();
  endtask

  task automatic do_exit(int exp_pd, int exp_sr, bit busy_in_wait);
    bus_busy = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 exclk state", lp_state, 6);
    check("R8 exclk clocks on", clkv(), 4'hF);
    check("R8 exclk pd held", pd_req, exp_pd);
    check("R8 exclk sr held", sr_req, exp_sr);
    check("R10 chg on exit", state_chg, 1);
    bus_busy = busy_in_wait;
    @(posedge clk); @(negedge clk);
    check("R8 exwait state", lp_state, 7);
    check("R8 exwait reqs low", {pd_req, sr_req}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy_in_wait ? "R9 busy ignored in wait" : "R8 waits ack", lp_state, 7);
    exit_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 back active", lp_state, 0);
    check("R10 chg on active", state_chg, 1);
    exit_ack = 1'b0;
    bus_busy = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; bus_busy = 1'b1; exit_ack = 1'b0; dram_type = 2'd0;
    pd_thr = '0; sr_thr = '0; srcg_thr = '0; srpd_thr = '0; sb_thr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 state in reset", lp_state, 0);
    check("R1 clocks in reset", clkv(), 4'hF);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 state", lp_state, 0);
    check("R1 reqs", {pd_req, sr_req}, 0);
    check("R1 clocks", clkv(), 4'hF);
    check("R1 chg", state_chg, 0);
  endtask

  task automatic t_walk_lp4();
    setup(2, 8, 1, 2, 3, 4000);
    adv_to(8);    check("R2 before pd", lp_state, 0);
    adv_to(9);    check("R2 pd state", lp_state, 1);
                  check("R2 pd_req", pd_req, 1);
                  check("R10 chg pulse", state_chg, 1);
    adv_to(10);   check("R10 chg drops", state_chg, 0);
    adv_to(1024); check("R3 before sr", lp_state, 1);
    adv_to(1025); check("R3 sr state", lp_state, 2);
                  check("R3 reqs", {pd_req, sr_req}, 2'b01);
                  check("R3 clocks", clkv(), 4'hF);
    adv_to(2048); check("R5 before srcg", lp_state, 2);
    adv_to(2049); check("R5 srcg state", lp_state, 3);
                  check("R5 sr held", sr_req, 1);
                  check("R5 clocks", clkv(), 4'h7);
    adv_to(3072); check("R6 before srpd", lp_state, 3);
    adv_to(3073); check("R6 srpd state", lp_state, 4);
                  check("R6 reqs", {pd_req, sr_req}, 2'b11);
                  check("R6 clocks", clkv(), 4'h7);
    adv_to(4000); check("R7 before stby", lp_state, 4);
    adv_to(4001); check("R7 stby state", lp_state, 5);
                  check("R7 reqs", {pd_req, sr_req}, 2'b01);
                  check("R7 clocks", clkv(), 4'h0);
    do_exit(0, 1, 1'b0);
  endtask

  task automatic t_ddr3_skip();
    setup(0, 8, 1, 2, 3, 4000);
    adv_to(2049); check("R5 srcg ddr3", lp_state, 3);
    adv_to(3100); check("R6 srpd skipped ddr3", lp_state, 3);
                  check("R6 pd low ddr3", pd_req, 0);
    adv_to(4001); check("R4 stby from srcg", lp_state, 5);
    do_exit(0, 1, 1'b1);
  endtask

  task automatic t_zero_skip();
    setup(2, 0, 1, 0, 0, 0);
    adv_to(50);   check("R4 pd disabled", lp_state, 0);
                  check("R4 pd_req low", pd_req, 0);
    adv_to(1024); check("R4 still active", lp_state, 0);
    adv_to(1025); check("R4 sr direct", lp_state, 2);
    adv_to(1600); check("R4 no deeper stage", lp_state, 2);
    do_exit(0, 1, 1'b0);
  endtask

  task automatic t_busy_clear();
    setup(0, 8, 0, 0, 0, 0);
    adv_to(5);
    pulse_busy();
    check("R9 busy keeps active", lp_state, 0);
    adv_to(8);    check("R9 count cleared", lp_state, 0);
    adv_to(9);    check("R9 pd after recount", lp_state, 1);
    do_exit(1, 0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_walk_lp4();
    t_ddr3_skip();
    t_zero_skip();
    t_busy_clear();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule